// File: doc/BRIEF.md
# Cascaded Fredkin-Gate Binary Decoder

This block turns an N-bit binary select value into a one-hot vector of 2^N lines. It is described gate by gate as a reversible network, so every gate has as many outputs as inputs and no signal is thrown away silently. The two most significant select bits go through a four-line base made of one Fredkin gate, one TR gate, an inverter and a CNOT. Each further select bit adds a stage that splits every line of the stage before it in two. The split uses one Fredkin gate per line, with the new bit as control and a constant zero on one data input.

Each Fredkin gate passes its control bit through unchanged. The block drives these copies, together with the base's spare output, onto a garbage bus, so that the whole reversible network is visible. The block also reports its Fredkin-gate count and its quantum cost on constant output ports. This lets a system integrator read them without repeating the arithmetic. The block is purely combinational and is legal for N from 2 to 6.

Top module: `fredkin_decoder`

## Requirements
- R1: For every select value, exactly one bit of `onehot` is 1.
- R2: The bit that is set is `onehot[sel]`, where `sel` is read as an unsigned binary number with bit 0 as its least significant bit.
- R3: Each stage's new select bit is the least significant bit of the output index. For every k, `onehot[2k] | onehot[2k+1]` equals 1 exactly when `sel[N-1:1]` equals k.
- R4: `garbage[0]` carries `sel[N-1]`. The stage that adds select bit `sel[N-s]`, for s from 3 to N, drives `garbage[2^(s-1)-3+k]` with `sel[N-s]` for each of its gates k, where k runs from 0 to 2^(s-1)-1. The bus is 2^N-3 bits wide.
- R5: `fredkin_count` equals 2^N-3. This is one gate in the base plus 2^(s-1) gates for each stage s.
- R6: `quantum_cost` equals 10+5*(2^N-4). This gives 10 for N=2, 30 for N=3 and 70 for N=4.
- R7: The outputs depend only on the current `sel` value. The block holds no state, so a new value is reflected within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel | input | N | Binary select value |
| onehot | output | 2^N | Decoded one-hot lines |
| garbage | output | 2^N-3 | Pass-through copies of the gate controls |
| fredkin_count | output | 16 | Constant number of Fredkin gates |
| quantum_cost | output | 16 | Constant total quantum cost |

## Verification
The decoder has no registers, so every result is due in the same cycle as the select value that causes it. The bench changes `sel` on the falling clock edge. It samples `onehot` and `garbage` 1 ns after the next rising edge, well after the network has settled and away from any edge. At that point it compares them with a behavioural model that sweeps every select value. The constant ports are compared once, after reset, against the closed-form counts for both a 3-bit and a 4-bit instance.

// File: rtl/fredkin_decoder.sv
`timescale 1ns/1ps
module fredkin_decoder #(
  parameter int N = 4
) (
  input  logic [N-1:0]        sel,
  output logic [(1<<N)-1:0]   onehot,
  output logic [(1<<N)-4:0]   garbage,
  output logic [15:0]         fredkin_count,
  output logic [15:0]         quantum_cost
);
  localparam int LINES  = 1 << N;
  localparam int GATES  = LINES - 3;
  localparam int QCOST  = 10 + 5 * (LINES - 4);

  if (N < 2 || N > 6) begin : g_bad_n
    $error("fredkin_decoder: N must be 2..6");
  end

  function automatic logic [2:0] fredkin(input logic c, input logic a, input logic b);
    return {c, c ? b : a, c ? a : b};
  endfunction

  for (genvar s = 2; s <= N; s++) begin : st
    logic [(1<<s)-1:0] v;
    if (s == 2) begin : g_base
      logic       x, y, tr_q, tr_r, nq;
      logic [2:0] f;
      assign x    = sel[N-1];
      assign y    = sel[N-2];
      assign f    = fredkin(x, y, 1'b0);
      assign tr_q = f[2] ^ y;
      assign tr_r = (f[2] & ~y) ^ 1'b0;
      assign nq   = ~tr_q;
      assign v[0] = f[0] ^ nq;
      assign v[1] = f[1];
      assign v[2] = tr_r;
      assign v[3] = f[0];
      assign garbage[0] = f[2];
    end else begin : g_split
      for (genvar k = 0; k < (1 << (s-1)); k++) begin : gt
        logic [2:0] f;
        assign f = fredkin(sel[N-s], st[s-1].v[k], 1'b0);
        assign v[2*k]   = f[1];
        assign v[2*k+1] = f[0];
        assign garbage[(1<<(s-1)) - 3 + k] = f[2];
      end
    end
  end

  assign onehot        = st[N].v;
  assign fredkin_count = 16'(GATES);
  assign quantum_cost  = 16'(QCOST);
endmodule

module fredkin_decoder_chk #(
  parameter int N = 4
) (
  input logic [N-1:0]      sel,
  input logic [(1<<N)-1:0] onehot,
  input logic [(1<<N)-4:0] garbage
);
  always_comb begin
    if (!$isunknown(sel) && !$isunknown(onehot) && !$isunknown(garbage)) begin
      // R1
      single_line_chk: assert ($countones(onehot) == 1);
      // R2
      index_match_chk: assert (onehot[sel] == 1'b1);
      // R3
      pair_split_chk: assert ((onehot[{sel[N-1:1], 1'b0}] | onehot[{sel[N-1:1], 1'b1}]) == 1'b1);
      // R4
      base_garbage_chk: assert (garbage[0] == sel[N-1]);
    end
  end
endmodule

bind fredkin_decoder fredkin_decoder_chk #(.N(N)) u_chk (
  .sel(sel), .onehot(onehot), .garbage(garbage)
);

// File: tb/fredkin_decoder_tb.sv
`timescale 1ns/1ps
module fredkin_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]  sel4;
  logic [15:0] oh4;
  logic [12:0] gb4;
  logic [15:0] fc4, qc4;
  logic [2:0]  sel3;
  logic [7:0]  oh3;
  logic [4:0]  gb3;
  logic [15:0] fc3, qc3;

  fredkin_decoder #(.N(4)) u_dut (
    .sel(sel4), .onehot(oh4), .garbage(gb4), .fredkin_count(fc4), .quantum_cost(qc4));
  fredkin_decoder #(.N(3)) u_dut3 (
    .sel(sel3), .onehot(oh3), .garbage(gb3), .fredkin_count(fc3), .quantum_cost(qc3));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_garbage(input int n, input int v);
    longint g = 0;
    g[0] = v[n-1];
    for (int s = 3; s <= n; s++)
      for (int k = 0; k < (1 << (s-1)); k++)
        g[(1<<(s-1)) - 3 + k] = v[n-s];
    return g;
  endfunction

  function automatic bit pair_ok(input int n, input longint oh, input int v);
    for (int k = 0; k < (1 << (n-1)); k++)
      if ((oh[2*k] | oh[2*k+1]) != ((v >> 1) == k)) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #4000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    sel4 = '0; sel3 = '0;
    repeat (3) @(posedge clk);
    #1;
    // R2: state during reset with zero select
    check(oh4 == 16'h0001, "R2 reset", oh4, 16'h0001);
    rst = 1'b0;
    // R5, R6
    check(fc4 == 16'd13, "R5 N=4", fc4, 13);
    check(qc4 == 16'd70, "R6 N=4", qc4, 70);
    check(fc3 == 16'd5,  "R5 N=3", fc3, 5);
    check(qc3 == 16'd30, "R6 N=3", qc3, 30);
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 16; i++) begin
        int v;
        v = (pass == 0) ? i : (i * 7 + 3) % 16;
        @(negedge clk);
        sel4 = 4'(v);
        sel3 = 3'(v);
        @(posedge clk);
        #1;
        // R7: same-cycle result
        check(oh4 == 16'(1 << v), "R2 R7 N=4", oh4, 1 << v);
        check($countones(oh4) == 1, "R1 N=4", $countones(oh4), 1);
        check(pair_ok(4, oh4, v), "R3 N=4", oh4, 1 << v);
        check(gb4 == 13'(exp_garbage(4, v)), "R4 N=4", gb4, exp_garbage(4, v));
        check(oh3 == 8'(1 << (v % 8)), "R2 N=3", oh3, 1 << (v % 8));
        check($countones(oh3) == 1, "R1 N=3", $countones(oh3), 1);
        check(pair_ok(3, oh3, v % 8), "R3 N=3", oh3, 1 << (v % 8));
        check(gb3 == 5'(exp_garbage(3, v % 8)), "R4 N=3", gb3, exp_garbage(3, v % 8));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule